// File: doc/BRIEF.md
# DDR YCbCr 4:2:2 Input Capture

This block sits at the edge of a video pipeline and takes an 8-bit-per-component YCbCr 4:2:2 stream from a parallel bus that changes on both clock edges. Horizontal sync, vertical sync and data-enable arrive as separate signals. Two single-edge registers stand in for the double-rate input cells. They collect the two half-samples of each clock period. The block pairs them in the configured edge order, picks the active byte lane off the wide bus, and undoes one of three pin-assignment styles.

The result is one 4:2:2 sample per clock. Each sample is a luma byte and a chroma byte, with a tag saying whether the chroma is Cb or Cr. The syncs travel through the same pipeline, so they stay in step with the data. The chroma tag restarts at Cb on every rising edge of data-enable, because the first active pixel always opens a Cb-Y-Cr-Y word.

The configuration inputs are treated as static while video is flowing.

Top module: `ycc422_ddr_capture`

## Requirements
- R1: While rst_n is low, every output is 0, whatever the bus and sync inputs do.
- R2: With cfg_style = 2'b10, the first-edge lane is the luma byte and the second-edge lane is the chroma byte.
- R3: With cfg_style = 2'b11, the first-edge lane is the chroma byte and the second-edge lane is the luma byte.
- R4: With cfg_style = 2'b01, each lane holds a chroma nibble in bits [7:4] and a luma nibble in bits [3:0]. The first-edge lane carries the low nibbles of both components and the second-edge lane carries the high nibbles.
- R5: With cfg_rise_first = 1, a pair is a rising-edge sample followed by the next falling-edge sample. With cfg_rise_first = 0, a pair is a falling-edge sample followed by the next rising-edge sample. In both cases the syncs and DE are sampled on the pair's rising edge.
- R6: cfg_justify = 2'b01 takes the lane from ddr_data[7:0] and cfg_justify = 2'b10 takes it from ddr_data[BUS_W-1:BUS_W-8]. The other bus bits have no effect on the outputs.
- R7: A cfg_style of 2'b00 decodes as style 2'b10. A cfg_justify of 2'b00 or 2'b11 decodes as 2'b01.
- R8: On the first output sample with de_out high after a low one, c_is_cr is 0 (Cb). It then inverts on every further sample while de_out stays high.
- R9: While de_out is low, y_out, c_out, c_is_cr and out_valid are 0. While de_out is high, out_valid is 1.
- R10: The outputs for a pair are valid after the second rising clock edge that follows the pair's rising edge. hsync_out, vsync_out and de_out carry the pair's sync values with that same latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-pair clock; data is sampled on both edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rise_first | input | 1 | 1: rising edge opens a pair; 0: falling edge opens a pair |
| cfg_style | input | 2 | Pin-assignment style: 01 nibble split, 10 luma first, 11 chroma first |
| cfg_justify | input | 2 | Lane position on the bus: 01 low bits, 10 high bits |
| ddr_data | input | BUS_W | Double-rate video bus |
| hsync_in | input | 1 | Horizontal sync |
| vsync_in | input | 1 | Vertical sync |
| de_in | input | 1 | Data enable |
| y_out | output | COMP_W | Luma of the sample |
| c_out | output | COMP_W | Chroma of the sample |
| c_is_cr | output | 1 | 0: c_out is Cb; 1: c_out is Cr |
| out_valid | output | 1 | Sample is active video |
| hsync_out | output | 1 | Aligned horizontal sync |
| vsync_out | output | 1 | Aligned vertical sync |
| de_out | output | 1 | Aligned data enable |

## Verification
A sample's outputs are due two rising edges after the rising edge of its pair, in both edge orders. With the falling edge first, the pair's first half arrives half a cycle before that rising edge. The bench drives the pair's rising-edge half just after a falling edge and its falling-edge half just after a rising edge. It then compares the sample from two iterations earlier, 2 ns after the current rising edge, so every result is read in the cycle it becomes due. The sync alignment is also checked against a three-sample history of the inputs, which holds only once three clocks have passed since reset.

// File: rtl/ycc_ddr_pkg.sv
package ycc_ddr_pkg;

   typedef enum logic [1:0] {
      STY_UNDEF        = 2'b00,
      STY_NIBBLE_SPLIT = 2'b01,
      STY_LUMA_FIRST   = 2'b10,
      STY_CHROMA_FIRST = 2'b11
   } pin_style_e;

   typedef enum logic [1:0] {
      JUST_UNDEF_LO = 2'b00,
      JUST_LOW      = 2'b01,
      JUST_HIGH     = 2'b10,
      JUST_UNDEF_HI = 2'b11
   } justify_e;

   typedef struct packed {
      logic hs;
      logic vs;
      logic de;
   } vctl_t;

endpackage

// File: rtl/ycc_ddr_edge_pair.sv
module ycc_ddr_edge_pair
   import ycc_ddr_pkg::*;
#(
   parameter int BUS_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise_first,
   input  logic [BUS_W-1:0] bus_i,
   input  vctl_t            ctl_i,
   output logic [BUS_W-1:0] first_o,
   output logic [BUS_W-1:0] second_o,
   output vctl_t            ctl_o
);

   logic [BUS_W-1:0] rise_q;
   logic [BUS_W-1:0] fall_q;
   logic [BUS_W-1:0] fall_hold;
   vctl_t            ctl_q;

   // Falling-edge half of the double-rate input.
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) fall_q <= '0;
      else        fall_q <= bus_i;
   end

   // Rising-edge half, plus the previous falling sample held for pairing.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_q    <= '0;
         fall_hold <= '0;
         ctl_q     <= '0;
      end else begin
         rise_q    <= bus_i;
         fall_hold <= fall_q;
         ctl_q     <= ctl_i;
      end
   end

   // Pair register: same latency for both edge orders.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_o  <= '0;
         second_o <= '0;
         ctl_o    <= '0;
      end else begin
         if (rise_first) begin
            first_o  <= rise_q;
            second_o <= fall_q;
         end else begin
            first_o  <= fall_hold;
            second_o <= rise_q;
         end
         ctl_o <= ctl_q;
      end
   end

endmodule

// File: rtl/ycc_ddr_lane_pick.sv
module ycc_ddr_lane_pick
   import ycc_ddr_pkg::*;
#(
   parameter int BUS_W  = 24,
   parameter int COMP_W = 8,
   parameter int HALVES = 2
) (
   input  logic [1:0]                    justify,
   input  logic [HALVES-1:0][BUS_W-1:0]  wide_i,
   output logic [HALVES-1:0][COMP_W-1:0] lane_o
);

   localparam int TOP_LSB = BUS_W - COMP_W;

   logic take_high;
   assign take_high = (justify_e'(justify) == JUST_HIGH);

   for (genvar g = 0; g < HALVES; g++) begin : g_lane
      assign lane_o[g] = take_high ? wide_i[g][TOP_LSB +: COMP_W]
                                   : wide_i[g][COMP_W-1:0];
   end

endmodule

// File: rtl/ycc_ddr_style_decode.sv
module ycc_ddr_style_decode
   import ycc_ddr_pkg::*;
#(
   parameter int COMP_W = 8
) (
   input  logic [1:0]        style,
   input  logic [COMP_W-1:0] lane_a,
   input  logic [COMP_W-1:0] lane_b,
   output logic [COMP_W-1:0] luma_o,
   output logic [COMP_W-1:0] chroma_o
);

   localparam int HALF = COMP_W / 2;

   always_comb begin
      case (pin_style_e'(style))
         STY_NIBBLE_SPLIT: begin
            luma_o   = {lane_b[HALF-1:0], lane_a[HALF-1:0]};
            chroma_o = {lane_b[COMP_W-1:HALF], lane_a[COMP_W-1:HALF]};
         end
         STY_CHROMA_FIRST: begin
            luma_o   = lane_b;
            chroma_o = lane_a;
         end
         default: begin
            luma_o   = lane_a;
            chroma_o = lane_b;
         end
      endcase
   end

endmodule

// File: rtl/ycc422_ddr_capture.sv
module ycc422_ddr_capture
   import ycc_ddr_pkg::*;
#(
   parameter int BUS_W  = 24,
   parameter int COMP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_rise_first,
   input  logic [1:0]        cfg_style,
   input  logic [1:0]        cfg_justify,
   input  logic [BUS_W-1:0]  ddr_data,
   input  logic              hsync_in,
   input  logic              vsync_in,
   input  logic              de_in,
   output logic [COMP_W-1:0] y_out,
   output logic [COMP_W-1:0] c_out,
   output logic              c_is_cr,
   output logic              out_valid,
   output logic              hsync_out,
   output logic              vsync_out,
   output logic              de_out
);

   localparam int HALVES = 2;

   if (COMP_W % 2 != 0) begin : g_bad_comp
      $error("COMP_W must be even for the nibble-split style");
   end
   if (BUS_W < COMP_W) begin : g_bad_bus
      $error("BUS_W must be at least COMP_W");
   end

   vctl_t                          ctl_in;
   vctl_t                          pair_ctl;
   logic [BUS_W-1:0]               pair_first;
   logic [BUS_W-1:0]               pair_second;
   logic [HALVES-1:0][BUS_W-1:0]   pair_bus;
   logic [HALVES-1:0][COMP_W-1:0]  lanes;
   logic [COMP_W-1:0]              dec_y;
   logic [COMP_W-1:0]              dec_c;

   assign ctl_in = '{hs: hsync_in, vs: vsync_in, de: de_in};

   ycc_ddr_edge_pair #(.BUS_W(BUS_W)) u_pair (
      .clk        (clk),
      .rst_n      (rst_n),
      .rise_first (cfg_rise_first),
      .bus_i      (ddr_data),
      .ctl_i      (ctl_in),
      .first_o    (pair_first),
      .second_o   (pair_second),
      .ctl_o      (pair_ctl)
   );

   assign pair_bus[0] = pair_first;
   assign pair_bus[1] = pair_second;

   ycc_ddr_lane_pick #(.BUS_W(BUS_W), .COMP_W(COMP_W), .HALVES(HALVES)) u_lane (
      .justify (cfg_justify),
      .wide_i  (pair_bus),
      .lane_o  (lanes)
   );

   ycc_ddr_style_decode #(.COMP_W(COMP_W)) u_dec (
      .style    (cfg_style),
      .lane_a   (lanes[0]),
      .lane_b   (lanes[1]),
      .luma_o   (dec_y),
      .chroma_o (dec_c)
   );

   // Output stage: chroma phase restarts on each DE rise.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         y_out     <= '0;
         c_out     <= '0;
         c_is_cr   <= 1'b0;
         out_valid <= 1'b0;
         hsync_out <= 1'b0;
         vsync_out <= 1'b0;
         de_out    <= 1'b0;
      end else begin
         hsync_out <= pair_ctl.hs;
         vsync_out <= pair_ctl.vs;
         de_out    <= pair_ctl.de;
         out_valid <= pair_ctl.de;
         if (pair_ctl.de) begin
            y_out   <= dec_y;
            c_out   <= dec_c;
            c_is_cr <= de_out ? ~c_is_cr : 1'b0;
         end else begin
            y_out   <= '0;
            c_out   <= '0;
            c_is_cr <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/ycc422_ddr_checker.sv
module ycc422_ddr_checker #(
   parameter int COMP_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hsync_in,
   input logic              vsync_in,
   input logic              de_in,
   input logic [COMP_W-1:0] y_out,
   input logic [COMP_W-1:0] c_out,
   input logic              c_is_cr,
   input logic              out_valid,
   input logic              hsync_out,
   input logic              vsync_out,
   input logic              de_out
);

   logic [1:0] warm_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               warm_cnt <= '0;
      else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
   end

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !de_out |-> (y_out == '0 && c_out == '0 && !c_is_cr && !out_valid)); // R9

   AST_CB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_cnt != 2'd0 && de_out && !$past(de_out)) |-> !c_is_cr); // R8

   AST_TAG_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_cnt != 2'd0 && de_out && $past(de_out)) |-> (c_is_cr != $past(c_is_cr))); // R8

   AST_SYNC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_cnt == 2'd3) |-> (hsync_out == $past(hsync_in, 3) &&
                              vsync_out == $past(vsync_in, 3) &&
                              de_out == $past(de_in, 3))); // R10

endmodule

bind ycc422_ddr_capture ycc422_ddr_checker #(.COMP_W(COMP_W)) u_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .hsync_in  (hsync_in),
   .vsync_in  (vsync_in),
   .de_in     (de_in),
   .y_out     (y_out),
   .c_out     (c_out),
   .c_is_cr   (c_is_cr),
   .out_valid (out_valid),
   .hsync_out (hsync_out),
   .vsync_out (vsync_out),
   .de_out    (de_out)
);

// File: tb/tb_ycc422_ddr_capture.sv
module tb_ycc422_ddr_capture;

   localparam int CLK_PERIOD = 10;
   localparam int BUS_W      = 24;
   localparam int MAXN       = 64;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_rise_first = 1'b1;
   logic [1:0]       cfg_style = 2'b10;
   logic [1:0]       cfg_justify = 2'b01;
   logic [BUS_W-1:0] ddr_data = '0;
   logic             hsync_in = 1'b0;
   logic             vsync_in = 1'b0;
   logic             de_in = 1'b0;
   logic [7:0]       y_out;
   logic [7:0]       c_out;
   logic             c_is_cr;
   logic             out_valid;
   logic             hsync_out;
   logic             vsync_out;
   logic             de_out;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ycc422_ddr_capture #(.BUS_W(BUS_W), .COMP_W(8)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_rise_first(cfg_rise_first),
      .cfg_style(cfg_style), .cfg_justify(cfg_justify), .ddr_data(ddr_data),
      .hsync_in(hsync_in), .vsync_in(vsync_in), .de_in(de_in),
      .y_out(y_out), .c_out(c_out), .c_is_cr(c_is_cr), .out_valid(out_valid),
      .hsync_out(hsync_out), .vsync_out(vsync_out), .de_out(de_out)
   );

   task automatic check_eq(input string req, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
      end
   endtask

   // Place a lane on the bus with noise in the unused bits (R6).
   function automatic logic [BUS_W-1:0] place(input logic [7:0] lane, input logic [1:0] jus);
      logic [15:0] noise;
      noise = {~lane, lane ^ 8'h5A};
      if (jus == 2'b10) return {lane, noise};
      else              return {noise, lane};
   endfunction

   // Expected decode from the style requirements (R2, R3, R4, R7).
   function automatic logic [15:0] model_yc(input logic [1:0] sty,
                                            input logic [7:0] a, input logic [7:0] b);
      case (sty)
         2'b01:   return {b[3:0], a[3:0], b[7:4], a[7:4]};
         2'b11:   return {b, a};
         default: return {a, b};
      endcase
   endfunction

   task automatic run_stream(input string tag, input logic [1:0] sty, input logic [1:0] jus,
                             input logic rf, input int n, input int seed, input bit gaps);
      logic [7:0] fa [MAXN];
      logic [7:0] sa [MAXN];
      logic       dea [MAXN];
      logic       hsa [MAXN];
      logic       vsa [MAXN];
      logic       exp_cr;
      logic [7:0] rv;
      logic [7:0] fv;
      for (int i = 0; i < MAXN; i++) begin
         fa[i]  = 8'((seed * 37 + i * 53 + 1) & 8'hFF);
         sa[i]  = 8'((seed * 91 + i * 29 + 7) & 8'hFF);
         hsa[i] = (i < n) && (i % 5 == 0);
         vsa[i] = (i < n) && (i % 11 == 2);
         if (i < 2 || i >= n) dea[i] = 1'b0;
         else dea[i] = gaps ? ((i % 7) != 3 && (i % 7) != 4) : 1'b1;
      end
      exp_cr = 1'b0;
      @(negedge clk);
      cfg_style = sty; cfg_justify = jus; cfg_rise_first = rf;
      for (int i = 0; i < n + 2; i++) begin
         @(negedge clk); #1;
         rv = rf ? sa[i] : sa[i];
         rv = rf ? fa[i] : sa[i];
         ddr_data = place(rv, jus);
         hsync_in = hsa[i]; vsync_in = vsa[i]; de_in = dea[i];
         @(posedge clk); #1;
         fv = rf ? sa[i] : fa[i+1];
         ddr_data = place(fv, jus);
         #1;
         if (i >= 2) begin
            int k;
            logic [15:0] yc;
            k = i - 2;
            if (dea[k]) begin
               exp_cr = (k > 0 && dea[k-1]) ? ~exp_cr : 1'b0;
               yc = model_yc(sty, fa[k], sa[k]);
            end else begin
               exp_cr = 1'b0;
               yc = 16'h0;
            end
            check_eq(tag, "y,c", {16'h0, y_out, c_out}, {16'h0, yc});
            check_eq(tag, "c_is_cr (R8)", {31'h0, c_is_cr}, {31'h0, exp_cr});
            check_eq(tag, "valid,de,hs,vs (R9 R10)",
                     {28'h0, out_valid, de_out, hsync_out, vsync_out},
                     {28'h0, dea[k], dea[k], hsa[k], vsa[k]});
         end
      end
   endtask

   task automatic test_reset();
      rst_n = 1'b0;
      @(negedge clk); #1;
      ddr_data = '1; de_in = 1'b1; hsync_in = 1'b1; vsync_in = 1'b1;
      repeat (3) @(posedge clk);
      #2;
      check_eq("R1", "outputs in reset",
               {8'h0, y_out, c_out, 1'b0, c_is_cr, out_valid, hsync_out, vsync_out, de_out},
               32'h0);
      @(negedge clk); #1;
      ddr_data = '0; de_in = 1'b0; hsync_in = 1'b0; vsync_in = 1'b0;
      rst_n = 1'b1;
      repeat (3) @(posedge clk);
   endtask

   task automatic test_luma_first();
      run_stream("R2 R5 R6 R10", 2'b10, 2'b01, 1'b1, 20, 3, 1'b0);
      run_stream("R2 R5 R6", 2'b10, 2'b10, 1'b0, 20, 4, 1'b0);
   endtask

   task automatic test_chroma_first();
      run_stream("R3 R5 R6", 2'b11, 2'b10, 1'b0, 20, 7, 1'b0);
      run_stream("R3 R5", 2'b11, 2'b01, 1'b1, 20, 8, 1'b0);
   endtask

   task automatic test_nibble_split();
      run_stream("R4 R5", 2'b01, 2'b01, 1'b1, 20, 11, 1'b0);
      run_stream("R4 R6", 2'b01, 2'b10, 1'b0, 20, 12, 1'b0);
   endtask

   task automatic test_defaults();
      run_stream("R7", 2'b00, 2'b11, 1'b1, 16, 13, 1'b0);
      run_stream("R7", 2'b00, 2'b00, 1'b0, 16, 14, 1'b0);
   endtask

   task automatic test_de_gaps();
      run_stream("R8 R9 R10", 2'b10, 2'b01, 1'b1, 40, 5, 1'b1);
      run_stream("R8 R9", 2'b11, 2'b10, 1'b0, 40, 6, 1'b1);
   endtask

   bit done = 1'b0;

   initial begin
      test_reset();
      test_luma_first();
      test_chroma_first();
      test_nibble_split();
      test_defaults();
      test_de_gaps();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog (R10): actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule